// File: doc/BRIEF.md
# Fault-Hardened Register File with One-Hot Checked Reads

This block holds a bank of 32 words, each 39 bits wide (32 data bits with 7 check bits), and gives two independent combinational read ports and one clocked write port. Location zero is hardwired: it holds no storage, and reading it returns a parameterised zero word whose check bits are already valid. Downstream integrity logic therefore sees a consistent codeword and does not flag an error. The block does not compute or inspect check bits. Every stored word is carried through unchanged.

The read path is built to resist a single upset bit in the read address logic. Each read address is first turned into a one-hot select vector, and that vector is checked for validity. The word is then taken through an AND-OR network in which every entry is masked by its own select bit, and the masked entries are ORed together. If a vector has no bit set, or has several bits set, the alert output rises. A corrupted address therefore shows up as an alarm instead of quietly returning a different register. A test-only mask input per port is XORed into each select vector after encoding, so that faults can be injected on purpose.

Top module: `hrf_regfile`

## Requirements
- R1: While reset is asserted and after it is released, with no write since, every location on both ports reads as the zero word parameter `ZeroWord`.
- R2: When `wr_en_i` is high and `wr_addr_i` is non-zero, the entry at `wr_addr_i` takes `wr_data_i` at the rising clock edge and is readable on either port after that edge.
- R3: When `wr_en_i` is low, no entry changes, whatever is on the address and data inputs.
- R4: A write to address 0 has no effect. A read of address 0 with a zero fault mask returns `ZeroWord`, not all zeros.
- R5: Both read paths are combinational. A change of read address or fault mask is reflected on the read data and on the alert with no clock edge.
- R6: Ports A and B decode their addresses independently, and each can read any entry, including the same entry, in the same cycle.
- R7: A select vector with no bit set, for example when the mask bit at the addressed position cancels the decoded bit, raises `alert_o` and gives all-zero read data on that port.
- R8: A select vector with two or more bits set raises `alert_o`, and that port returns the bitwise OR of all selected entries.
- R9: `alert_o` is the OR of the port A and port B checks, so a fault on either port alone raises it.
- R10: When both fault masks are zero, `alert_o` stays low for every pair of read addresses. A mask that moves the single set bit to another position also leaves `alert_o` low and reads the entry at the new position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes land on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Write location |
| wr_data_i | input | 39 | Word to store |
| rd_addr_a_i | input | 5 | Port A read location |
| rd_data_a_o | output | 39 | Port A read word |
| rd_addr_b_i | input | 5 | Port B read location |
| rd_data_b_o | output | 39 | Port B read word |
| flip_a_i | input | 32 | Test mask XORed into the port A select vector |
| flip_b_i | input | 32 | Test mask XORed into the port B select vector |
| alert_o | output | 1 | High when either select vector is not one-hot |

## Verification
Every location is loaded with a word that encodes its own index. A wrong decode then shows up as a different value, and an OR of entries shows up as a merged pattern. Clean reads on both ports, including the lowest, highest and same-address cases, separate correct decoding from cross-port interference. Injected masks that empty a vector, add a bit, flood it, or move its bit to another one-hot position separate the alert conditions from the data each produces. The moved-bit case shows that the check judges only the shape of the vector. Writes with the strobe low and writes to location zero are each followed by reads of the location they could have changed.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned HRF_NUM_REGS = 32;
  localparam int unsigned HRF_WORD_W   = 39;
  localparam int unsigned HRF_ADDR_W   = $clog2(HRF_NUM_REGS);
  localparam logic [HRF_WORD_W-1:0] HRF_ZERO_WORD = 39'h2A_0000_0000;
endpackage

// File: rtl/hrf_onehot_enc.sv
module hrf_onehot_enc #(
  parameter int unsigned NumRegs = 32,
  localparam int unsigned AddrW  = $clog2(NumRegs)
) (
  input  logic [AddrW-1:0]   addr_i,
  input  logic [NumRegs-1:0] flip_i,
  output logic [NumRegs-1:0] sel_o
);
  for (genvar g = 0; g < NumRegs; g++) begin : g_bit
    assign sel_o[g] = (addr_i == AddrW'(g)) ^ flip_i[g];
  end
endmodule

// File: rtl/hrf_onehot_chk.sv
module hrf_onehot_chk #(
  parameter int unsigned NumRegs = 32
) (
  input  logic [NumRegs-1:0] sel_i,
  output logic               err_o
);
  logic any_set;
  logic multi_set;

  always_comb begin
    any_set   = 1'b0;
    multi_set = 1'b0;
    for (int i = 0; i < NumRegs; i++) begin
      multi_set = multi_set | (any_set & sel_i[i]);
      any_set   = any_set | sel_i[i];
    end
  end

  assign err_o = multi_set | ~any_set;
endmodule

// File: rtl/hrf_andor_mux.sv
module hrf_andor_mux #(
  parameter int unsigned NumRegs = 32,
  parameter int unsigned WordW   = 39
) (
  input  logic [WordW-1:0]   words_i [NumRegs],
  input  logic [NumRegs-1:0] sel_i,
  output logic [WordW-1:0]   word_o
);
  logic [WordW-1:0] masked [NumRegs];

  for (genvar g = 0; g < NumRegs; g++) begin : g_mask
    assign masked[g] = words_i[g] & {WordW{sel_i[g]}};
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NumRegs; i++) begin
      word_o = word_o | masked[i];
    end
  end
endmodule

// File: rtl/hrf_regfile.sv
module hrf_regfile #(
  parameter int unsigned NumRegs = hrf_pkg::HRF_NUM_REGS,
  parameter int unsigned WordW   = hrf_pkg::HRF_WORD_W,
  parameter logic [WordW-1:0] ZeroWord = hrf_pkg::HRF_ZERO_WORD,
  localparam int unsigned AddrW  = $clog2(NumRegs)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AddrW-1:0]   wr_addr_i,
  input  logic [WordW-1:0]   wr_data_i,
  input  logic [AddrW-1:0]   rd_addr_a_i,
  output logic [WordW-1:0]   rd_data_a_o,
  input  logic [AddrW-1:0]   rd_addr_b_i,
  output logic [WordW-1:0]   rd_data_b_o,
  input  logic [NumRegs-1:0] flip_a_i,
  input  logic [NumRegs-1:0] flip_b_i,
  output logic               alert_o
);
  logic [WordW-1:0]   words [NumRegs];
  logic [NumRegs-1:0] sel_a;
  logic [NumRegs-1:0] sel_b;
  logic               err_a;
  logic               err_b;

  // Location zero: constant codeword, no storage.
  assign words[0] = ZeroWord;

  for (genvar g = 1; g < NumRegs; g++) begin : g_entry
    logic             upd;
    logic [WordW-1:0] ent_d;
    logic [WordW-1:0] ent_q;

    assign upd = wr_en_i && (wr_addr_i == AddrW'(g));

    always_comb begin
      ent_d = ent_q;
      if (upd) ent_d = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= ZeroWord;
      else         ent_q <= ent_d;
    end

    assign words[g] = ent_q;
  end

  hrf_onehot_enc #(.NumRegs(NumRegs)) enc_a_i (
    .addr_i(rd_addr_a_i), .flip_i(flip_a_i), .sel_o(sel_a));
  hrf_onehot_enc #(.NumRegs(NumRegs)) enc_b_i (
    .addr_i(rd_addr_b_i), .flip_i(flip_b_i), .sel_o(sel_b));

  hrf_onehot_chk #(.NumRegs(NumRegs)) chk_a_i (.sel_i(sel_a), .err_o(err_a));
  hrf_onehot_chk #(.NumRegs(NumRegs)) chk_b_i (.sel_i(sel_b), .err_o(err_b));

  hrf_andor_mux #(.NumRegs(NumRegs), .WordW(WordW)) mux_a_i (
    .words_i(words), .sel_i(sel_a), .word_o(rd_data_a_o));
  hrf_andor_mux #(.NumRegs(NumRegs), .WordW(WordW)) mux_b_i (
    .words_i(words), .sel_i(sel_b), .word_o(rd_data_b_o));

  assign alert_o = err_a | err_b;
endmodule

// File: rtl/hrf_regfile_chk.sv
module hrf_regfile_chk #(
  parameter int unsigned NumRegs = 32,
  parameter int unsigned WordW   = 39,
  parameter logic [WordW-1:0] ZeroWord = '0,
  localparam int unsigned AddrW  = $clog2(NumRegs)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AddrW-1:0]   wr_addr_i,
  input logic [WordW-1:0]   wr_data_i,
  input logic [AddrW-1:0]   rd_addr_a_i,
  input logic [WordW-1:0]   rd_data_a_o,
  input logic [NumRegs-1:0] flip_a_i,
  input logic [NumRegs-1:0] flip_b_i,
  input logic [NumRegs-1:0] sel_a,
  input logic [NumRegs-1:0] sel_b,
  input logic               alert_o
);
  assert_clean_no_alert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_a_i == '0 && flip_b_i == '0) |-> !alert_o);

  assert_zero_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0 && flip_a_i == '0) |-> (rd_data_a_o == ZeroWord));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=>
      ((rd_addr_a_i != $past(wr_addr_i)) || (flip_a_i != '0) ||
       (rd_data_a_o == $past(wr_data_i))));

  assert_alert_tracks_shape_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o == (($countones(sel_a) != 1) || ($countones(sel_b) != 1)));

  assert_empty_sel_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a == '0) |-> (rd_data_a_o == '0 && alert_o));
endmodule

bind hrf_regfile hrf_regfile_chk #(
  .NumRegs(NumRegs), .WordW(WordW), .ZeroWord(ZeroWord)
) assert_chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
  .flip_a_i(flip_a_i), .flip_b_i(flip_b_i), .sel_a(sel_a), .sel_b(sel_b),
  .alert_o(alert_o)
);

// File: tb/hrf_regfile_tb_top.sv
module hrf_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int W = 39;
  localparam logic [W-1:0] ZW = 39'h2A_0000_0000;

  typedef struct packed {
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ma;
    logic [31:0] mb;
    logic        exp_alert;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd2,  32'h0,         32'h0,         1'b0}, // R6 R10 clean
    '{5'd31, 5'd0,  32'h0,         32'h0,         1'b0}, // R10 edges
    '{5'd7,  5'd7,  32'h0,         32'h0,         1'b0}, // R6 same entry
    '{5'd3,  5'd4,  32'h0000_0008, 32'h0,         1'b1}, // R7 emptied
    '{5'd3,  5'd4,  32'h0000_0200, 32'h0,         1'b1}, // R8 extra bit
    '{5'd10, 5'd12, 32'h0,         32'h0010_0000, 1'b1}, // R9 B only
    '{5'd5,  5'd9,  32'h0000_0060, 32'h0,         1'b0}, // R10 moved bit
    '{5'd0,  5'd6,  32'h0000_0002, 32'h0,         1'b1}, // R8 x0 plus r1
    '{5'd8,  5'd2,  32'h0,         32'hFFFF_FFFF, 1'b1}, // R8 flood B
    '{5'd0,  5'd0,  32'h0,         32'h0,         1'b0}  // R4 zero both
  };

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         wr_en_i;
  logic [4:0]   wr_addr_i;
  logic [W-1:0] wr_data_i;
  logic [4:0]   rd_addr_a_i, rd_addr_b_i;
  logic [W-1:0] rd_data_a_o, rd_data_b_o;
  logic [N-1:0] flip_a_i, flip_b_i;
  logic         alert_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [W-1:0] model [N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hrf_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
    .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o),
    .flip_a_i(flip_a_i), .flip_b_i(flip_b_i), .alert_o(alert_o));

  function automatic logic [W-1:0] pattern(input int idx);
    return {7'(idx * 5 + 1), 16'hC3A0 | 16'(idx), 16'(idx) << 4 | 16'h8001};
  endfunction

  function automatic logic [W-1:0] expect_read(input logic [4:0] a, input logic [31:0] m);
    logic [31:0] sel;
    logic [W-1:0] acc;
    sel = (32'd1 << a) ^ m;
    acc = '0;
    for (int i = 0; i < N; i++) if (sel[i]) acc = acc | model[i];
    return acc;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input logic en, input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    wr_en_i = en; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (en && a != 0) model[a] = d;
  endtask

  task automatic set_read(input logic [4:0] a, input logic [4:0] b,
                          input logic [31:0] ma, input logic [31:0] mb);
    rd_addr_a_i = a; rd_addr_b_i = b; flip_a_i = ma; flip_b_i = mb;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = ZW;
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    set_read(5'd0, 5'd0, '0, '0);
    // Write attempted during reset must not stick
    wr_en_i = 1'b1; wr_addr_i = 5'd9; wr_data_i = '1;
    repeat (3) @(negedge clk_i);
    set_read(5'd9, 5'd17, '0, '0);
    check("R1 reset port A", rd_data_a_o, ZW);
    check("R1 reset port B", rd_data_b_o, ZW);
    wr_en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    set_read(5'd31, 5'd1, '0, '0);
    check("R1 after release A", rd_data_a_o, ZW);
    check("R1 after release B", rd_data_b_o, ZW);
    check("R10 alert idle", {38'b0, alert_o}, '0);

    for (int i = 1; i < N; i++) do_write(1'b1, 5'(i), pattern(i));
    set_read(5'd13, 5'd27, '0, '0);
    check("R2 write read A", rd_data_a_o, pattern(13));
    check("R2 write read B", rd_data_b_o, pattern(27));

    // R3 strobe low
    do_write(1'b0, 5'd5, 39'h7F_FFFF_FFFF);
    set_read(5'd5, 5'd5, '0, '0);
    check("R3 no write when strobe low", rd_data_a_o, pattern(5));

    // R4 write to x0 ignored
    do_write(1'b1, 5'd0, 39'h55_1234_5678);
    set_read(5'd0, 5'd0, '0, '0);
    check("R4 x0 reads zero word A", rd_data_a_o, ZW);
    check("R4 x0 reads zero word B", rd_data_b_o, ZW);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      set_read(VECS[v].ra, VECS[v].rb, VECS[v].ma, VECS[v].mb);
      check($sformatf("R6 R7 R8 vec%0d data A", v), rd_data_a_o,
            expect_read(VECS[v].ra, VECS[v].ma));
      check($sformatf("R6 R8 vec%0d data B", v), rd_data_b_o,
            expect_read(VECS[v].rb, VECS[v].mb));
      check($sformatf("R9 R10 vec%0d alert", v), {38'b0, alert_o},
            {38'b0, VECS[v].exp_alert});
    end

    // R7 directed: emptied vector gives zero data
    set_read(5'd20, 5'd1, 32'h0010_0000, '0);
    check("R7 empty vector data", rd_data_a_o, '0);
    check("R7 empty vector alert", {38'b0, alert_o}, 39'd1);

    // R5 combinational: change address mid-phase, no clock edge
    @(posedge clk_i); #1;
    set_read(5'd11, 5'd12, '0, '0);
    check("R5 comb read A", rd_data_a_o, pattern(11));
    set_read(5'd11, 5'd12, '0, 32'h0000_0001);
    check("R5 comb alert", {38'b0, alert_o}, 39'd1);
    check("R8 B or merge", rd_data_b_o, pattern(12) | ZW);

    // R2 overwrite then same-cycle read
    do_write(1'b1, 5'd31, 39'h01_DEAD_BEEF);
    set_read(5'd31, 5'd30, '0, '0);
    check("R2 overwrite top", rd_data_a_o, 39'h01_DEAD_BEEF);
    check("R2 neighbour intact", rd_data_b_o, pattern(30));

    finish_run();
  end
endmodule